// File: doc/BRIEF.md
# Arbitrated Single-Byte DMA Bus Master

This block runs one system-bus memory access for each request it accepts. It requests ownership of the bus with a hold request and waits for the arbiter's acknowledge, which arrives asynchronously and is passed through a synchronizer. After the acknowledge is seen, the block waits a fixed number of clocks and then enables its drivers. It then performs the transfer phases T1, T2, zero or more Tw wait states, and T3. After the transfer it gives the bus back.

The 24-bit address is split across two output buses. The low 16 bits go on a dedicated address bus. The top 8 bits share the 8-bit address/data bus with the data and are marked by the address latch enable in T1. The bus is arbitrated for every byte, so a new transfer always starts with a fresh hold request. The hold request must stay low for a minimum time between transfers.

The request side uses a valid/ready handshake. `req_ready` is high only while the block is idle. A request presented at any other time is stalled and must stay stable until it is accepted. The response is a one-cycle `rsp_valid` pulse with the read byte, and it cannot be back-pressured: the user must take it in the cycle it appears.

Top module: `dma_bus_master`

## Requirements
- R1: `req_ready` is high only in the idle state, a request is taken on a clock edge with `req_valid` and `req_ready` both high, and `req_ready` stays low from acceptance until the block is idle again.
- R2: After acceptance `hold_req` rises. `bus_oe` stays low until the synchronized acknowledge has been seen, then rises exactly SYNC_STAGES+EN_DLY+1 rising edges after `hold_ack` goes high (5 with defaults).
- R3: In T1, the first driven cycle, `ale` is high for exactly one clock. `addr_lo` carries address bits 15:0, `ad_out` carries bits 23:16 with `ad_oe` high, and both strobes are high.
- R4: The strobe (`rd_n` low for a read, `wr_n` low for a write, never both) goes low in the cycle after T1. `mem_ready` is sampled at the edge closing each strobe cycle, and each low sample adds one wait cycle, so the strobe is low for 1 + (number of low samples) cycles.
- R5: A read captures `ad_in` at the edge where `mem_ready` is sampled high and returns it on `rsp_rdata` with `rsp_valid`. A write drives the write byte on `ad_out` with `ad_oe` high from T2 through T3.
- R6: One byte per grant: T3 is the last driven cycle, and it carries the one-cycle `rsp_valid` pulse. In the next cycle `hold_req` and `bus_oe` are low.
- R7: Once `hold_req` falls it stays low for at least HOLD_LOW_MIN clocks (2 by default) before rising again.
- R8: Withdrawing `hold_ack` after the grant does not abort the transfer. The transfer completes and `hold_req` stays high until T3.
- R9: Without an acknowledge, `hold_req` stays high indefinitely. Only the asynchronous active-high `rst` lowers it without a completed transfer.
- R10: During and right after reset, `hold_req`, `bus_oe`, `ale`, `ad_oe` and `rsp_valid` are low, both strobes are high, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Transfer finished (one-cycle pulse) |
| rsp_rdata | output | 8 | Byte read |
| hold_req | output | 1 | Bus hold request |
| hold_ack | input | 1 | Asynchronous bus grant |
| bus_oe | output | 1 | Address/strobe driver enable |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_lo | output | 16 | Address bits 15:0 |
| ad_out | output | 8 | Multiplexed address bits 23:16 / write data |
| ad_oe | output | 1 | Enable for `ad_out` |
| ad_in | input | 8 | Read data from memory |
| mem_ready | input | 1 | Memory ready, sampled during strobe cycles |

## Verification
The hardest situations to create are a grant that is withdrawn while the transfer is already running, and a hold request that is never answered. The bench's arbiter model can drop `hold_ack` on the first cycle the drivers turn on, while the memory model adds random wait states. This makes the transfer outlive its acknowledge by several cycles. In a directed case the arbiter model holds back the acknowledge for dozens of cycles, and the bench then ends the wait with an asynchronous reset.

// File: rtl/dma_bm_pkg.sv
package dma_bm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_SYNC, S_T1, S_T2, S_TW, S_T3, S_GAP
  } bm_state_e;
endpackage

// File: rtl/dma_bm_sync.sv
module dma_bm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dma_bm_fsm.sv
module dma_bm_fsm
  import dma_bm_pkg::*;
#(
  parameter int EN_DLY       = 2,
  parameter int HOLD_LOW_MIN = 2,
  parameter int CNT_W        = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic ack_s,
  input  logic mem_ready,
  output logic req_ready,
  output logic accept,
  output logic hold_req,
  output logic bus_oe,
  output logic ale,
  output logic strobe,
  output logic capture,
  output logic rsp_valid
);
  localparam logic [CNT_W-1:0] EN_LAST  = CNT_W'(EN_DLY - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(HOLD_LOW_MIN - 1);

  bm_state_e state, nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:     if (req_valid) nxt = S_REQ;
      S_REQ:      if (ack_s) nxt = S_SYNC;
      S_SYNC:     if (cnt == EN_LAST) nxt = S_T1;
      S_T1:       nxt = S_T2;
      S_T2, S_TW: nxt = mem_ready ? S_T3 : S_TW;
      S_T3:       nxt = S_GAP;
      S_GAP:      if (cnt == GAP_LAST) nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)                          cnt <= '0;
      else if (state == S_SYNC || state == S_GAP) cnt <= cnt + 1'b1;
    end
  end

  assign req_ready = (state == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign hold_req  = (state == S_REQ) || (state == S_SYNC) || bus_oe;
  assign bus_oe    = (state == S_T1) || strobe || (state == S_T3);
  assign ale       = (state == S_T1);
  assign strobe    = (state == S_T2) || (state == S_TW);
  assign capture   = strobe && mem_ready;
  assign rsp_valid = (state == S_T3);
endmodule

// File: rtl/dma_bm_datapath.sv
module dma_bm_datapath #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     accept,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     capture,
  input  logic                     bus_oe,
  input  logic                     ale,
  input  logic                     strobe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-DATA_W-1:0] addr_lo,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [DATA_W-1:0]        rsp_rdata
);
  localparam int LO_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic              wr_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addr_q    <= '0;
      wdat_q    <= '0;
      wr_q      <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        wdat_q <= req_wdata;
        wr_q   <= req_write;
      end
      if (capture && !wr_q) rsp_rdata <= ad_in;
    end
  end

  assign rd_n    = !(strobe && !wr_q);
  assign wr_n    = !(strobe && wr_q);
  assign addr_lo = bus_oe ? addr_q[LO_W-1:0] : '0;
  assign ad_out  = !bus_oe ? '0 : (ale ? addr_q[ADDR_W-1:LO_W] : wdat_q);
  assign ad_oe   = bus_oe && (ale || wr_q);
endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master #(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int EN_DLY       = 2,
  parameter int HOLD_LOW_MIN = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     hold_req,
  input  logic                     hold_ack,
  output logic                     bus_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-DATA_W-1:0] addr_lo,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  input  logic                     mem_ready
);
  localparam int CNT_MAX = (EN_DLY > HOLD_LOW_MIN) ? EN_DLY : HOLD_LOW_MIN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic ack_s, accept, strobe, capture;

  dma_bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(hold_ack), .q(ack_s)
  );

  dma_bm_fsm #(
    .EN_DLY(EN_DLY), .HOLD_LOW_MIN(HOLD_LOW_MIN), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ack_s(ack_s),
    .mem_ready(mem_ready), .req_ready(req_ready), .accept(accept),
    .hold_req(hold_req), .bus_oe(bus_oe), .ale(ale), .strobe(strobe),
    .capture(capture), .rsp_valid(rsp_valid)
  );

  dma_bm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .capture(capture),
    .bus_oe(bus_oe), .ale(ale), .strobe(strobe), .ad_in(ad_in),
    .rd_n(rd_n), .wr_n(wr_n), .addr_lo(addr_lo), .ad_out(ad_out),
    .ad_oe(ad_oe), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/dma_bus_master_chk.sv
module dma_bus_master_chk #(
  parameter int HOLD_LOW_MIN = 2
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic hold_req,
  input logic bus_oe,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic mem_ready
);
  localparam int LW = $clog2(HOLD_LOW_MIN + 1) + 1;
  localparam logic [LW-1:0] LMAX = LW'(HOLD_LOW_MIN);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                     low_cnt <= LMAX;
    else if (hold_req)           low_cnt <= '0;
    else if (low_cnt < LMAX)     low_cnt <= low_cnt + 1'b1;
  end

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !hold_req);

  assert_drive_needs_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> hold_req);

  assert_ale_then_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> (!ale && (!rd_n || !wr_n)));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  assert_wait_extends_R4: assert property (@(posedge clk) disable iff (rst)
    ((!rd_n || !wr_n) && !mem_ready) |=> (!rd_n || !wr_n));

  assert_release_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!hold_req && !bus_oe));

  assert_low_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_req) |-> (low_cnt >= LMAX));

  assert_hold_until_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_req) |-> $past(rsp_valid));
endmodule

bind dma_bus_master dma_bus_master_chk #(.HOLD_LOW_MIN(HOLD_LOW_MIN)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .hold_req(hold_req), .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n),
  .wr_n(wr_n), .mem_ready(mem_ready)
);

// File: tb/dma_bus_master_tb.sv
module dma_bus_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_EN = 5;   // SYNC_STAGES + EN_DLY + 1
  localparam int LOW_MIN = 2;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [23:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic hold_ack = 0, mem_ready = 0;
  logic req_ready, rsp_valid, hold_req, bus_oe, ale, rd_n, wr_n, ad_oe;
  logic [7:0] rsp_rdata, ad_out;
  logic [15:0] addr_lo;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // model configuration / observations
  int waits = 0, ack_dly = 0, ack_cnt = 0, cyc = 0, ack_cyc = 0, en_delay = 0;
  int strobe_cnt = 0, low_run = 100, hold_rises = 0;
  bit drop = 0, ack_done = 0, ack_allowed = 1, saw_rd = 0, saw_wr = 0;
  bit prev_hold = 0, prev_oe = 0, seen_fall = 0;
  logic [23:0] obs_addr = '0;
  logic [7:0] wdata_seen = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_bus_master u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hold_req(hold_req),
    .hold_ack(hold_ack), .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .addr_lo(addr_lo), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .mem_ready(mem_ready)
  );

  function automatic logic [7:0] memf(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // arbiter + memory model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        hold_ack = 0; mem_ready = 0; ack_cnt = 0;
      end else begin
        if (!hold_req) begin
          if (prev_hold) seen_fall = 1;
          low_run++;
          hold_ack = 0; ack_cnt = 0;
        end else begin
          if (!prev_hold) begin
            hold_rises++;
            if (seen_fall) chk(low_run >= LOW_MIN, "R7 hold low run", low_run, LOW_MIN);
          end
          low_run = 0;
          if (!hold_ack && !ack_done && ack_allowed) begin
            if (ack_cnt >= ack_dly) begin
              hold_ack = 1; ack_cyc = cyc; ack_done = 1;
            end else ack_cnt++;
          end
        end
        if (bus_oe && !prev_oe) begin
          en_delay = cyc - ack_cyc;
          if (drop) hold_ack = 0;   // R8: grant withdrawn early
        end
        if (ale) begin
          obs_addr = {ad_out, addr_lo};
          chk(ad_oe && rd_n && wr_n, "R3 ale phase drive", {ad_oe, rd_n, wr_n}, 3'b111);
        end
        if (!rd_n || !wr_n) begin
          strobe_cnt++;
          mem_ready = (strobe_cnt > waits);
          if (!rd_n) saw_rd = 1;
          if (!wr_n) begin
            saw_wr = 1; wdata_seen = ad_out;
            chk(ad_oe, "R5 write data enable", ad_oe, 1);
          end
        end else mem_ready = 0;
        ad_in = memf(obs_addr);
        if (rsp_valid) chk(hold_req && bus_oe, "R8 hold kept through T3", hold_req, 1);
      end
      prev_hold = hold_req;
      prev_oe = bus_oe;
    end
  end

  task automatic xfer(bit w, logic [23:0] a, logic [7:0] d, int wt, int ad, bit dr);
    int rises0;
    int t;
    waits = wt; ack_dly = ad; drop = dr; ack_done = 0;
    strobe_cnt = 0; saw_rd = 0; saw_wr = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rises0 = hold_rises;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready && hold_req, "R1 ready low while busy", req_ready, 0);
    t = 0;
    while (!rsp_valid && t < 500) begin @(negedge clk); t++; end
    chk(rsp_valid, "R8 transfer completes", rsp_valid, 1);
    chk(obs_addr == a, "R3 address", obs_addr, a);
    chk(strobe_cnt == wt + 1, "R4 strobe length", strobe_cnt, wt + 1);
    chk(en_delay == EXP_EN, "R2 enable delay", en_delay, EXP_EN);
    if (w) begin
      chk(saw_wr && !saw_rd, "R4 write strobe only", {saw_wr, saw_rd}, 2'b10);
      chk(wdata_seen == d, "R5 write data", wdata_seen, d);
    end else begin
      chk(saw_rd && !saw_wr, "R4 read strobe only", {saw_rd, saw_wr}, 2'b10);
      chk(rsp_rdata == memf(a), "R5 read data", rsp_rdata, memf(a));
    end
    @(negedge clk);
    chk(!hold_req && !bus_oe && !rsp_valid, "R6 release after T3",
        {hold_req, bus_oe, rsp_valid}, 0);
    chk(hold_rises - rises0 == 1, "R6 one grant per byte", hold_rises - rises0, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!hold_req && !bus_oe && !ale && !ad_oe && rd_n && wr_n && req_ready && !rsp_valid,
        "R10 reset state", {hold_req, bus_oe, ale, ad_oe, rd_n, wr_n, req_ready}, 7'b0000111);
    rst = 0;
    @(negedge clk);
    chk(!hold_req && req_ready && rd_n && wr_n, "R10 after reset", {hold_req, req_ready}, 2'b01);

    // directed corners
    xfer(0, 24'hABCDEF, 8'h00, 0, 0, 0);
    xfer(1, 24'h123456, 8'hC3, 0, 0, 0);
    xfer(0, 24'hFFFFFF, 8'h00, 7, 3, 0);
    xfer(1, 24'h000000, 8'hFF, 4, 0, 1);
    xfer(0, 24'h800001, 8'h00, 2, 5, 1);

    // constrained random
    for (int i = 0; i < 40; i++) begin
      xfer(1'($urandom % 2), 24'($urandom), 8'($urandom), int'($urandom % 6),
           int'($urandom % 4), 1'($urandom % 3 == 0));
    end

    // R9: grant never given, only reset lowers the request
    begin
      bit held;
      ack_allowed = 0; ack_done = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 24'h55AA55;
      @(negedge clk);
      req_valid = 0;
      held = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!hold_req || bus_oe) held = 0;
      end
      chk(held, "R9 request held without grant", held, 1);
      #(CLK_PERIOD/4) rst = 1;
      #1;
      chk(!hold_req && req_ready && !bus_oe, "R9 reset clears request", hold_req, 0);
      @(negedge clk);
      rst = 0;
      ack_allowed = 1;
      repeat (3) @(negedge clk);
    end
    xfer(1, 24'h0F0F0F, 8'h5A, 1, 1, 0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end
endmodule